// File: doc/BRIEF.md
# PLL Clock Control and Status Registers

This block holds the software-visible control and status state of a PLL clock module. A multiplier register selects the PLL ratio; a value of zero means bypass. A power-down bit turns the PLL off, and a guard keeps it consistent with the multiplier. A sticky flag records an oscillator failure. A lock bit reports whether the PLL has settled after its ratio changed. The analog PLL is replaced by a lock-wait counter. Every accepted multiplier write reloads that counter with `LOCK_CYCLES`.

Software reaches the block through a one-address-bit register port. Writes land only while the protection input is high. Any write that breaks a rule is dropped whole and raises a one-cycle error pulse.

The clock-failure detector and the source-switch logic drive the flag from outside. The block returns a clock-source selection code and the PLL power-down control. The two hard resets (external and watchdog) restore every default. The two soft resets (missing-clock and debugger) return the multiplier to bypass but leave the status bits alone.

Top module: `pll_ctl_regs`

## Requirements
- R1: After `ext_rst_n` or `wdog_rst_n` is asserted, the multiplier reads 0, the status word reads 0x0001 (lock=1, all other bits 0), `clk_sel` is 0, `pll_pd` is 0 and `wr_err` is 0.
- R2: A `mclk_det` pulse sets the missing-clock flag (status bit 3) at the next clock edge.
- R3: A write of bit 3 has no effect on the flag. The flag clears only on an accepted status write with bit 4 set, or on R4's event. When `mclk_det` falls in the same cycle as either clear, the flag stays 1.
- R4: A `src_switch` pulse clears the flag at the next edge, unless R3's same-cycle rule applies.
- R5: A status write with bit 2 set is accepted only while the multiplier is 0. Otherwise it is blocked, and the power-down bit keeps its value.
- R6: While the power-down bit is 1, a multiplier write with a non-zero value is blocked, and the multiplier keeps its value.
- R7: An accepted multiplier write, including a write of zero, clears the lock bit (status bit 0) for exactly `LOCK_CYCLES` cycles. A new accepted write during that time restarts the full count.
- R8: A write is blocked in any of these cases, and leaves every register unchanged:
  - `prot_en` is low;
  - it sets status bit 1 or any status bit at position 5 or above;
  - it sets a multiplier bit at position `MULT_W` or above.
- R9: Every blocked write, including those of R5 and R6, raises `wr_err` for exactly the one cycle after the write edge.
- R10: A `mclk_rst` or `dbg_rst` pulse sets the multiplier to 0 and the lock bit to 1. It leaves status bits 2 and 3 unchanged.
- R11: `pll_pd` equals the power-down bit OR `lp_mode`. The PLL therefore stays down after `lp_mode` falls while the bit is set.
- R12: `clk_sel` encodings and priority:
  - 3 while the flag is set (limp mode);
  - else 2 while locking (oscillator divided by 2);
  - else 1 when the multiplier is non-zero;
  - else 0 (bypass).
- R13: `addr`=0 reads the multiplier in bits [`MULT_W`-1:0], with zeros above. `addr`=1 reads lock at bit 0, 0 at bit 1, power-down at bit 2 and the flag at bit 3. Bit 4 and everything above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| wdog_rst_n | input | 1 | Watchdog reset, active low, asynchronous |
| mclk_rst | input | 1 | Missing-clock reset pulse, synchronous |
| dbg_rst | input | 1 | Debugger reset pulse, synchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 selects multiplier, 1 selects status |
| wdata | input | 16 | Write data |
| prot_en | input | 1 | Write-protection release; writes land only while high |
| rdata | output | 16 | Read data for `addr` |
| wr_err | output | 1 | One-cycle pulse after a blocked write |
| mclk_det | input | 1 | Oscillator-missing detect pulse |
| src_switch | input | 1 | Automatic source-switch event pulse |
| lp_mode | input | 1 | Halt or standby low-power mode active |
| clk_sel | output | 2 | Clock source code (R12) |
| pll_pd | output | 1 | PLL power-down control |

## Verification
The two flag paths that can collide are the fault detector setting the flag and a clearing action: a software clear write or the automatic source switch. The bench drives `mclk_det` high in the very cycle that a status write carries the clear bit. It repeats the collision with `src_switch` in place of the write. In both cases the flag must still read 1 after the edge, because a fault must never be lost. A clear alone in the following cycle must then drop the flag to 0.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;

  typedef enum logic [1:0] {
    CSEL_OSC  = 2'd0,
    CSEL_PLL  = 2'd1,
    CSEL_DIV2 = 2'd2,
    CSEL_LIMP = 2'd3
  } clk_sel_e;

  // status word bit positions (software decodes them)
  localparam int STS_LOCK  = 0;
  localparam int STS_RSVD  = 1;
  localparam int STS_OFF   = 2;
  localparam int STS_MFLAG = 3;
  localparam int STS_MCLR  = 4;

  // clock source priority: limp > div2 > pll > bypass oscillator
  function automatic clk_sel_e pick_clk(input logic flag, input logic locking,
                                        input logic mult_nz);
    if (flag)         return CSEL_LIMP;
    else if (locking) return CSEL_DIV2;
    else if (mult_nz) return CSEL_PLL;
    else              return CSEL_OSC;
  endfunction

  // does a data word set any bit outside the legal mask
  function automatic logic has_illegal(input logic [15:0] data, input logic [15:0] legal);
    return (data & ~legal) != '0;
  endfunction

endpackage

// File: rtl/pll_wr_guard.sv
module pll_wr_guard
  import pll_ctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MULT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              prot_en,
  input  logic [MULT_W-1:0] mult_q,
  input  logic              pll_off_q,
  output logic              mult_wr_ok,
  output logic              sts_wr_ok,
  output logic              wr_block,
  output logic              wr_err
);

  localparam logic [15:0] STS_LEGAL  = 16'((1 << STS_LOCK) | (1 << STS_OFF) |
                                           (1 << STS_MFLAG) | (1 << STS_MCLR));
  localparam logic [15:0] MULT_LEGAL = 16'((1 << MULT_W) - 1);

  logic [15:0] wd16;
  logic        deny_prot, deny_rsvd, deny_off, deny_mult;

  assign wd16 = 16'(wdata);

  always_comb begin
    deny_prot = !prot_en;
    deny_rsvd = addr ? has_illegal(wd16, STS_LEGAL) : has_illegal(wd16, MULT_LEGAL);
    deny_off  = addr && wd16[STS_OFF] && (mult_q != '0);
    deny_mult = !addr && (wd16[MULT_W-1:0] != '0) && pll_off_q;
  end

  assign wr_block   = wr_en && (deny_prot || deny_rsvd || deny_off || deny_mult);
  assign mult_wr_ok = wr_en && !addr && !wr_block;
  assign sts_wr_ok  = wr_en &&  addr && !wr_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= wr_block;
  end

  // R8: a write without protection release is reported next cycle
  a_r8_prot_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !prot_en) |=> wr_err);

  // R9: an error pulse always follows a write strobe
  a_r9_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en));

endmodule

// File: rtl/pll_mult_lock.sv
module pll_mult_lock #(
  parameter int MULT_W      = 4,
  parameter int LOCK_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              mult_wr_ok,
  input  logic [MULT_W-1:0] mult_wdata,
  output logic [MULT_W-1:0] mult_q,
  output logic              locked,
  output logic              lock_start
);

  localparam int CW = $clog2(LOCK_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] count_down(input logic [CW-1:0] c);
    return (c == '0) ? c : c - CW'(1);
  endfunction

  assign lock_start = mult_wr_ok && !soft_rst;
  assign locked     = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= '0;
      cnt_q  <= '0;
    end else if (soft_rst) begin
      mult_q <= '0;
      cnt_q  <= '0;
    end else if (mult_wr_ok) begin
      mult_q <= mult_wdata;
      cnt_q  <= CW'(LOCK_CYCLES);
    end else begin
      cnt_q  <= count_down(cnt_q);
    end
  end

  // R7: every accepted write drops lock on the next cycle
  a_r7_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
    lock_start |=> !locked);

  // R10: a soft reset lands in stable bypass
  a_r10_soft_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (locked && mult_q == '0));

endmodule

// File: rtl/pll_sts_bits.sv
module pll_sts_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic sts_wr_ok,
  input  logic wr_off,
  input  logic wr_clr,
  input  logic mclk_det,
  input  logic src_switch,
  output logic pll_off_q,
  output logic mflag_q,
  output logic flag_clr_ev
);

  // a clear comes from software or from the automatic source switch
  assign flag_clr_ev = (sts_wr_ok && wr_clr) || src_switch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_off_q <= 1'b0;
      mflag_q   <= 1'b0;
    end else begin
      if (sts_wr_ok)        pll_off_q <= wr_off;
      if (mclk_det)         mflag_q   <= 1'b1;
      else if (flag_clr_ev) mflag_q   <= 1'b0;
    end
  end

  // R2: a detect pulse always sets the flag
  a_r2_det_sets: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_det |=> mflag_q);

  // R3: without a clear event the flag holds
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mflag_q && !flag_clr_ev) |=> mflag_q);

  // R4: a switch event without a fault clears it
  a_r4_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (src_switch && !mclk_det) |=> !mflag_q);

  // R5: the power-down bit changes only on an accepted write
  a_r5_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_wr_ok |=> $stable(pll_off_q));

endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
  import pll_ctl_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int MULT_W      = 4,
  parameter int LOCK_CYCLES = 32
) (
  input  logic              clk,
  input  logic              ext_rst_n,
  input  logic              wdog_rst_n,
  input  logic              mclk_rst,
  input  logic              dbg_rst,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              prot_en,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_err,
  input  logic              mclk_det,
  input  logic              src_switch,
  input  logic              lp_mode,
  output logic [1:0]        clk_sel,
  output logic              pll_pd
);

  logic              por_n;
  logic              soft_rst;
  logic              mult_wr_ok, sts_wr_ok, wr_block;
  logic [MULT_W-1:0] mult_q;
  logic              locked, lock_start;
  logic              pll_off_q, mflag_q, flag_clr_ev;
  logic [DATA_W-1:0] sts_word;
  clk_sel_e          csel;

  // only the hard resets reach the register state
  assign por_n    = ext_rst_n & wdog_rst_n;
  assign soft_rst = mclk_rst | dbg_rst;

  pll_wr_guard #(.DATA_W(DATA_W), .MULT_W(MULT_W)) u_guard (
    .clk       (clk),
    .rst_n     (por_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .prot_en   (prot_en),
    .mult_q    (mult_q),
    .pll_off_q (pll_off_q),
    .mult_wr_ok(mult_wr_ok),
    .sts_wr_ok (sts_wr_ok),
    .wr_block  (wr_block),
    .wr_err    (wr_err)
  );

  pll_mult_lock #(.MULT_W(MULT_W), .LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk       (clk),
    .rst_n     (por_n),
    .soft_rst  (soft_rst),
    .mult_wr_ok(mult_wr_ok),
    .mult_wdata(wdata[MULT_W-1:0]),
    .mult_q    (mult_q),
    .locked    (locked),
    .lock_start(lock_start)
  );

  pll_sts_bits u_sts (
    .clk        (clk),
    .rst_n      (por_n),
    .sts_wr_ok  (sts_wr_ok),
    .wr_off     (wdata[STS_OFF]),
    .wr_clr     (wdata[STS_MCLR]),
    .mclk_det   (mclk_det),
    .src_switch (src_switch),
    .pll_off_q  (pll_off_q),
    .mflag_q    (mflag_q),
    .flag_clr_ev(flag_clr_ev)
  );

  always_comb begin
    sts_word            = '0;
    sts_word[STS_LOCK]  = locked;
    sts_word[STS_OFF]   = pll_off_q;
    sts_word[STS_MFLAG] = mflag_q;
  end

  assign rdata   = addr ? sts_word : DATA_W'(mult_q);
  assign csel    = pick_clk(mflag_q, !locked, mult_q != '0);
  assign clk_sel = csel;
  assign pll_pd  = pll_off_q | lp_mode;

  // R6: the PLL is never off with a non-bypass multiplier
  a_r6_off_bypass: assert property (@(posedge clk) disable iff (!por_n)
    pll_off_q |-> (mult_q == '0));

  // R11: a set power-down bit always drives the power-down pin
  a_r11_pd_follows: assert property (@(posedge clk) disable iff (!por_n)
    pll_off_q |-> pll_pd);

  // R12: a flagged fault always selects limp mode
  a_r12_limp: assert property (@(posedge clk) disable iff (!por_n)
    mflag_q |-> (clk_sel == 2'd3));

  // R9: a blocked write leaves the multiplier as it was
  a_r9_block_keeps: assert property (@(posedge clk) disable iff (!por_n)
    (wr_block && !soft_rst) |=> $stable(mult_q));

endmodule

// File: tb/pll_ctl_regs_bench.sv
module pll_ctl_regs_bench;
  localparam int  N  = 12;
  localparam time TP = 8ns;

  logic        clk = 1'b0;
  logic        ext_rst_n = 1'b0, wdog_rst_n = 1'b1, mclk_rst = 1'b0, dbg_rst = 1'b0;
  logic        wr_en = 1'b0, addr = 1'b0, prot_en = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        wr_err, mclk_det = 1'b0, src_switch = 1'b0, lp_mode = 1'b0, pll_pd;
  logic [1:0]  clk_sel;
  int          total = 0, bad = 0;

  always #(TP/2) clk = ~clk;

  pll_ctl_regs #(.DATA_W(16), .MULT_W(4), .LOCK_CYCLES(N)) u_pll_ctl_regs (
    .clk(clk), .ext_rst_n(ext_rst_n), .wdog_rst_n(wdog_rst_n), .mclk_rst(mclk_rst),
    .dbg_rst(dbg_rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .prot_en(prot_en),
    .rdata(rdata), .wr_err(wr_err), .mclk_det(mclk_det), .src_switch(src_switch),
    .lp_mode(lp_mode), .clk_sel(clk_sel), .pll_pd(pll_pd)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  // one write cycle; returns just after the following falling edge
  task automatic wr(input logic a, input logic [15:0] d, input logic prot);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; prot_en = prot;
    @(negedge clk); wr_en = 1'b0; prot_en = 1'b1; wdata = '0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic t_defaults(input string tag);
    logic [15:0] v;
    rd(1'b0, v); check({tag, " mult"}, v, 16'h0000);
    rd(1'b1, v); check({tag, " status"}, v, 16'h0001);
    check({tag, " clk_sel"}, 16'(clk_sel), 16'd0);
    check({tag, " pll_pd"}, 16'(pll_pd), 16'd0);
    check({tag, " wr_err"}, 16'(wr_err), 16'd0);
  endtask

  task automatic t_lock;
    logic [15:0] v;
    wr(1'b0, 16'h0005, 1'b1);
    rd(1'b1, v); check("R7 lock low after write", v & 16'h1, 16'h0);
    check("R12 div2 while locking", 16'(clk_sel), 16'd2);
    repeat (N-1) @(negedge clk);
    rd(1'b1, v); check("R7 still locking at N-1", v & 16'h1, 16'h0);
    @(negedge clk);
    rd(1'b1, v); check("R7 locked at N", v & 16'h1, 16'h1);
    check("R12 pll source", 16'(clk_sel), 16'd1);
    rd(1'b0, v); check("R13 mult readback", v, 16'h0005);
    wr(1'b0, 16'h0003, 1'b1);
    repeat (5) @(negedge clk);
    wr(1'b0, 16'h0006, 1'b1);
    repeat (N-1) @(negedge clk);
    rd(1'b1, v); check("R7 restart keeps lock low", v & 16'h1, 16'h0);
    @(negedge clk);
    rd(1'b1, v); check("R7 restart locks at N", v & 16'h1, 16'h1);
  endtask

  task automatic t_guards;
    logic [15:0] v;
    wr(1'b1, 16'h0004, 1'b1);
    check("R9 err on off-with-mult", 16'(wr_err), 16'd1);
    rd(1'b1, v); check("R5 off refused", v & 16'h4, 16'h0);
    @(negedge clk); check("R9 err one cycle", 16'(wr_err), 16'd0);
    wr(1'b0, 16'h0000, 1'b1);
    repeat (N) @(negedge clk);
    check("R12 bypass", 16'(clk_sel), 16'd0);
    wr(1'b1, 16'h0004, 1'b1);
    check("R5 no err when bypass", 16'(wr_err), 16'd0);
    rd(1'b1, v); check("R5 off accepted", v, 16'h0005);
    check("R11 pd on", 16'(pll_pd), 16'd1);
    wr(1'b0, 16'h0003, 1'b1);
    check("R9 err on mult while off", 16'(wr_err), 16'd1);
    rd(1'b0, v); check("R6 mult unchanged", v, 16'h0000);
    rd(1'b1, v); check("R6 lock untouched", v & 16'h1, 16'h1);
    pulse(lp_mode);
    check("R11 pd stays after wake", 16'(pll_pd), 16'd1);
    wr(1'b1, 16'h0000, 1'b1);
    check("R11 pd off", 16'(pll_pd), 16'd0);
    @(negedge clk); lp_mode = 1'b1; #1;
    check("R11 pd follows lp_mode", 16'(pll_pd), 16'd1);
    @(negedge clk); lp_mode = 1'b0; #1;
    check("R11 pd drops after wake", 16'(pll_pd), 16'd0);
  endtask

  task automatic t_protect;
    logic [15:0] v;
    wr(1'b0, 16'h0007, 1'b0);
    check("R8 err when protected", 16'(wr_err), 16'd1);
    rd(1'b0, v); check("R8 mult unchanged", v, 16'h0000);
    rd(1'b1, v); check("R8 lock unchanged", v, 16'h0001);
    wr(1'b1, 16'h0002, 1'b1);
    check("R8 err reserved bit1", 16'(wr_err), 16'd1);
    wr(1'b1, 16'h0024, 1'b1);
    check("R8 err high status bit", 16'(wr_err), 16'd1);
    rd(1'b1, v); check("R8 status unchanged", v, 16'h0001);
    wr(1'b0, 16'h0100, 1'b1);
    check("R8 err high mult bit", 16'(wr_err), 16'd1);
    rd(1'b1, v); check("R8 no lock restart", v, 16'h0001);
  endtask

  task automatic t_flag;
    logic [15:0] v;
    pulse(mclk_det);
    rd(1'b1, v); check("R2 flag set", v & 16'h8, 16'h8);
    check("R12 limp", 16'(clk_sel), 16'd3);
    wr(1'b1, 16'h0008, 1'b1);
    rd(1'b1, v); check("R3 bit3 write ignored", v & 16'h8, 16'h8);
    check("R3 bit3 write no err", 16'(wr_err), 16'd0);
    @(negedge clk); addr = 1'b1; wdata = 16'h0010; wr_en = 1'b1; mclk_det = 1'b1;
    @(negedge clk); wr_en = 1'b0; mclk_det = 1'b0; wdata = '0;
    rd(1'b1, v); check("R3 set wins over clear", v & 16'h8, 16'h8);
    wr(1'b1, 16'h0010, 1'b1);
    rd(1'b1, v); check("R3 software clear", v, 16'h0001);
    check("R13 clear bit reads 0", v & 16'h10, 16'h0);
    pulse(mclk_det);
    @(negedge clk); src_switch = 1'b1; mclk_det = 1'b1;
    @(negedge clk); src_switch = 1'b0; mclk_det = 1'b0;
    rd(1'b1, v); check("R3 set wins over switch", v & 16'h8, 16'h8);
    pulse(src_switch);
    rd(1'b1, v); check("R4 switch clears flag", v & 16'h8, 16'h0);
  endtask

  task automatic t_soft;
    logic [15:0] v;
    wr(1'b0, 16'h0009, 1'b1);
    pulse(mclk_det);
    pulse(mclk_rst);
    rd(1'b0, v); check("R10 mult cleared", v, 16'h0000);
    rd(1'b1, v); check("R10 flag kept, lock 1", v, 16'h0009);
    wr(1'b1, 16'h0004, 1'b1);
    pulse(dbg_rst);
    rd(1'b1, v); check("R10 off kept over dbg", v, 16'h000D);
    @(negedge clk); wdog_rst_n = 1'b0;
    @(negedge clk); wdog_rst_n = 1'b1;
    t_defaults("R1 watchdog");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    ext_rst_n = 1'b1;
    @(negedge clk);
    t_defaults("R1 external");
    t_lock();
    t_guards();
    t_protect();
    t_flag();
    t_soft();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(TP * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule